// File: doc/BRIEF.md
# Count/Compare Timer Interrupt Unit

This block keeps a free-running 32-bit tick counter next to a 32-bit comparison register. When the counter reaches the comparison value, a timer request is raised. The request stays up until software writes a new comparison value. The counter advances by one on each cycle in which the tick enable is high. The tick enable is meant to strobe at a nominal 100 MHz rate. Software can write and read both registers through plain write strobes and always-valid read buses.

A freeze input stops the counter and stops new requests from being raised. The count reached so far is kept, so counting resumes from the same value when the freeze is released. A 3-bit revision input decides whether a sticky pending status bit is maintained. A 3-bit routing input picks which of eight interrupt lines carries the request.

Top module: `cnt_cmp_timer`

## Requirements
- R1: With tick enable high, freeze low and no count write, the count rises by exactly one per clock and wraps from 0xFFFFFFFF to 0x00000000.
- R2: While freeze is high, the count holds its value and no new timer request is raised, even if the count equals the compare value.
- R3: When the count becomes equal to the compare value while freeze is low, the timer request is high from the following clock onward.
- R4: A compare write lowers the timer request at the next clock. This holds even in the same cycle as a new equality. The request is not raised again until the two registers next become equal after having differed.
- R5: When the revision input equals 1, the pending status bit is set by a match and cleared by a compare write.
- R6: When the revision input is any value other than 1, the pending status bit keeps its value through matches and compare writes.
- R7: The request appears only on interrupt line number `route_sel`. The other seven lines stay low, and all eight are low when no request is pending.
- R8: After reset, the count reads 1, the compare reads 0, and the request, all lines and the pending bit are low.
- R9: Freezing and then unfreezing keeps the accumulated count, and counting resumes from that value.
- R10: A count write loads the written value at the next clock and takes priority over a tick in the same cycle.
- R11: Changing `route_sel` while a request is pending moves the request to the newly selected line in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Count advance strobe |
| freeze | input | 1 | Stops counting and new requests |
| count_wr_en | input | 1 | Count write strobe |
| count_wr_data | input | 32 | Count write value |
| cmp_wr_en | input | 1 | Compare write strobe; clears the request |
| cmp_wr_data | input | 32 | Compare write value |
| rev_sel | input | 3 | Revision field; value 1 enables the pending bit |
| route_sel | input | 3 | Index of the interrupt line that carries the request |
| count_rd | output | 32 | Current count |
| cmp_rd | output | 32 | Current compare value |
| irq_lines | output | 8 | One-hot-or-zero interrupt lines |
| timer_pending | output | 1 | Sticky pending status bit |

## Verification
The assertions assume that every input is stable and known around each rising edge, and that reset is held for at least one clock.

The assertions also assume that the revision and routing fields may change in any cycle. The properties therefore compare against the values sampled in the same or the previous cycle, not against a fixed setting.

The bench changes every input only on the falling edge. It raises each write strobe for exactly one clock, and it reaches equality only by counting up to it or by a direct count write.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned CNT_W     = 32;
  localparam int unsigned NUM_LINES = 8;
  localparam int unsigned SEL_W     = $clog2(NUM_LINES);
  localparam int unsigned REV_W     = 3;
  localparam logic [REV_W-1:0] PEND_REV = REV_W'(1);
  localparam logic [CNT_W-1:0] CNT_RST  = CNT_W'(1);
  localparam logic [CNT_W-1:0] CMP_RST  = '0;
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_en,
  input  logic         freeze,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] value
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= RST_VAL;
    else if (wr_en)      cnt_q <= wr_data;
    else if (tick_en && !freeze) cnt_q <= cnt_q + W'(1);
  end

  assign value = cnt_q;

  // R1
  cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_en && !freeze && !wr_en) |=> (cnt_q == $past(cnt_q) + W'(1)));
  // R2
  cnt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (freeze && !wr_en) |=> $stable(cnt_q));
  // R10
  cnt_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (cnt_q == $past(wr_data)));
endmodule

// File: rtl/tmr_match.sv
module tmr_match #(
  parameter int unsigned W = 32,
  parameter int unsigned RW = 3,
  parameter logic [W-1:0] CMP_RST = '0,
  parameter logic [RW-1:0] PEND_REV = RW'(1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  count,
  input  logic          freeze,
  input  logic          cmp_wr_en,
  input  logic [W-1:0]  cmp_wr_data,
  input  logic [RW-1:0] rev_sel,
  output logic [W-1:0]  cmp_value,
  output logic          irq,
  output logic          pending
);
  logic [W-1:0] cmp_q;
  logic eq, eq_prev_q, hit, irq_q, pend_q, pend_on;

  assign eq      = (count == cmp_q);
  assign hit     = eq && !eq_prev_q && !freeze;
  assign pend_on = (rev_sel == PEND_REV);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cmp_q     <= CMP_RST;
      eq_prev_q <= 1'b0;
      irq_q     <= 1'b0;
      pend_q    <= 1'b0;
    end else begin
      eq_prev_q <= eq;
      if (cmp_wr_en) cmp_q <= cmp_wr_data;
      if (cmp_wr_en)  irq_q <= 1'b0;
      else if (hit)   irq_q <= 1'b1;
      if (pend_on) begin
        if (cmp_wr_en)  pend_q <= 1'b0;
        else if (hit)   pend_q <= 1'b1;
      end
    end
  end

  assign cmp_value = cmp_q;
  assign irq       = irq_q;
  assign pending   = pend_q;

  // R4
  cmp_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr_en |=> !irq_q);
  // R2
  freeze_no_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    freeze |=> !$rose(irq_q));
  // R3
  match_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eq && !eq_prev_q && !freeze && !cmp_wr_en) |=> irq_q);
  // R6
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_on |=> $stable(pend_q));
  // R5
  pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_on && cmp_wr_en) |=> !pend_q);
endmodule

// File: rtl/tmr_route.sv
module tmr_route #(
  parameter int unsigned N = 8,
  parameter int unsigned SW = 3
) (
  input  logic          req,
  input  logic [SW-1:0] sel,
  output logic [N-1:0]  lines
);
  for (genvar i = 0; i < N; i++) begin : g_line
    assign lines[i] = req && (sel == SW'(i));
  end

  // R7
  always_comb begin
    route_onehot_chk: assert ($onehot0(lines));
  end
endmodule

// File: rtl/cnt_cmp_timer.sv
module cnt_cmp_timer
  import tmr_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 tick_en,
  input  logic                 freeze,
  input  logic                 count_wr_en,
  input  logic [CNT_W-1:0]     count_wr_data,
  input  logic                 cmp_wr_en,
  input  logic [CNT_W-1:0]     cmp_wr_data,
  input  logic [REV_W-1:0]     rev_sel,
  input  logic [SEL_W-1:0]     route_sel,
  output logic [CNT_W-1:0]     count_rd,
  output logic [CNT_W-1:0]     cmp_rd,
  output logic [NUM_LINES-1:0] irq_lines,
  output logic                 timer_pending
);
  logic [CNT_W-1:0] count_w;
  logic irq_w;

  tmr_counter #(.W(CNT_W), .RST_VAL(CNT_RST)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .freeze(freeze),
    .wr_en(count_wr_en), .wr_data(count_wr_data), .value(count_w)
  );

  tmr_match #(.W(CNT_W), .RW(REV_W), .CMP_RST(CMP_RST), .PEND_REV(PEND_REV)) u_match (
    .clk(clk), .rst_n(rst_n), .count(count_w), .freeze(freeze),
    .cmp_wr_en(cmp_wr_en), .cmp_wr_data(cmp_wr_data), .rev_sel(rev_sel),
    .cmp_value(cmp_rd), .irq(irq_w), .pending(timer_pending)
  );

  tmr_route #(.N(NUM_LINES), .SW(SEL_W)) u_route (
    .req(irq_w), .sel(route_sel), .lines(irq_lines)
  );

  assign count_rd = count_w;

  // R11
  route_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_lines[route_sel] == irq_w);
endmodule

// File: tb/cnt_cmp_timer_tb.sv
module cnt_cmp_timer_tb_top;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0, tick_en = 0, freeze = 0;
  logic count_wr_en = 0, cmp_wr_en = 0;
  logic [31:0] count_wr_data = 0, cmp_wr_data = 0;
  logic [2:0] rev_sel = 3'd1, route_sel = 0;
  logic [31:0] count_rd, cmp_rd;
  logic [7:0] irq_lines;
  logic timer_pending;

  int total = 0, bad = 0;
  logic pend_exp = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  cnt_cmp_timer dut_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .freeze(freeze),
    .count_wr_en(count_wr_en), .count_wr_data(count_wr_data),
    .cmp_wr_en(cmp_wr_en), .cmp_wr_data(cmp_wr_data),
    .rev_sel(rev_sel), .route_sel(route_sel),
    .count_rd(count_rd), .cmp_rd(cmp_rd),
    .irq_lines(irq_lines), .timer_pending(timer_pending)
  );

  // vector: {offset[7:0], route[2:0], rev[2:0]}
  localparam logic [13:0] VECS [0:5] = '{
    {8'd5, 3'd0, 3'd1}, {8'd1, 3'd7, 3'd1}, {8'd9, 3'd3, 3'd2},
    {8'd3, 3'd5, 3'd0}, {8'd2, 3'd2, 3'd1}, {8'd4, 3'd6, 3'd7}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_count(input logic [31:0] v);
    count_wr_en = 1; count_wr_data = v;
    @(negedge clk); count_wr_en = 0;
  endtask

  task automatic wr_cmp(input logic [31:0] v);
    cmp_wr_en = 1; cmp_wr_data = v;
    if (rev_sel == 3'd1) pend_exp = 0;
    @(negedge clk); cmp_wr_en = 0;
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R8 reset state
    check("R8 count", count_rd, 32'd1);
    check("R8 cmp", cmp_rd, 32'd0);
    check("R8 lines", {24'd0, irq_lines}, 32'd0);
    check("R8 pend", {31'd0, timer_pending}, 32'd0);

    // table walk: R3 R5 R6 R7
    foreach (VECS[k]) begin
      rev_sel = VECS[k][2:0]; route_sel = VECS[k][5:3];
      wr_count(32'd100);
      wr_cmp(32'd100 + VECS[k][13:6]);
      check("R4 cleared", {24'd0, irq_lines}, 32'd0);
      tick_en = 1;
      repeat (VECS[k][13:6]) @(negedge clk);
      tick_en = 0;
      check("R1 count", count_rd, 32'd100 + VECS[k][13:6]);
      @(negedge clk);
      if (rev_sel == 3'd1) pend_exp = 1;
      check("R3/R7 lines", {24'd0, irq_lines}, 32'd1 << VECS[k][5:3]);
      check("R5/R6 pend", {31'd0, timer_pending}, {31'd0, pend_exp});
    end

    // R11 route change while pending
    route_sel = 3'd4; #1;
    check("R11 moved", {24'd0, irq_lines}, 32'h10);

    // R6 compare write with rev!=1 leaves pending alone
    rev_sel = 3'd1; wr_cmp(32'd5);
    rev_sel = 3'd1; wr_count(32'd4); wr_cmp(32'd5);
    tick_en = 1; @(negedge clk); tick_en = 0; @(negedge clk);
    check("R5 set", {31'd0, timer_pending}, 32'd1);
    rev_sel = 3'd3; wr_cmp(32'd6);
    check("R6 kept", {31'd0, timer_pending}, 32'd1);
    check("R4 low", {24'd0, irq_lines}, 32'd0);
    rev_sel = 3'd1;

    // R4 compare write in the match cycle
    wr_count(32'd200); wr_cmp(32'd201);
    tick_en = 1; @(negedge clk);
    tick_en = 0; cmp_wr_en = 1; cmp_wr_data = 32'd201; pend_exp = 0;
    @(negedge clk); cmp_wr_en = 0;
    check("R4 same cycle", {24'd0, irq_lines}, 32'd0);
    repeat (3) @(negedge clk);
    check("R4 no reassert", {24'd0, irq_lines}, 32'd0);
    check("R5 cleared", {31'd0, timer_pending}, 32'd0);

    // R2 freeze with equality
    wr_cmp(32'd300);
    freeze = 1; tick_en = 1;
    wr_count(32'd300);
    repeat (3) @(negedge clk);
    check("R2 held", count_rd, 32'd300);
    check("R2 no irq", {24'd0, irq_lines}, 32'd0);
    // R9 resume from preserved count
    freeze = 0;
    repeat (2) @(negedge clk);
    check("R9 resumed", count_rd, 32'd302);

    // R10 write wins over tick
    count_wr_en = 1; count_wr_data = 32'hABCD;
    @(negedge clk); count_wr_en = 0; tick_en = 0;
    check("R10 priority", count_rd, 32'hABCD);

    // R1 wrap
    wr_count(32'hFFFF_FFFF);
    tick_en = 1; @(negedge clk); tick_en = 0;
    check("R1 wrap", count_rd, 32'd0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule